// File: doc/BRIEF.md
# Dual-clause MDIO management master

This block is the management-bus master that a host uses to reach the registers of Ethernet PHYs over the two-wire MDC/MDIO bus. It takes register writes from a simple single-cycle register port and turns them into serial management frames. One frame engine produces both the short-address framing and the extended framing that has a separate address phase. A configuration bit chooses between the two. MDC is derived from the system clock by a programmable divider. MDIO is carried as three plain pins (drive value, drive enable, sampled input), and the tri-state pad sits outside the block.

The host sets the framing mode and the divider in the status/config register, then loads the PHY and device address fields in the control register. In extended mode, a write to the register-address register sends an address frame. A write to the data register sends a write frame. A control write with the read command bit set sends a read frame. The 16 bits returned by the PHY land in the data register, and the read-error flag records a PHY that did not answer. In short-address mode, the device field of the control register carries the PHY register number and no address frame is sent.

The register port has no back-pressure. Every write is taken in the cycle it is presented, and a write that arrives while a frame is running has no effect. Readback is combinational from the addressed register.

Top module: `mdio_master`

## Requirements
- R1: After reset the status/config register (word 0) reads 0x0400: busy (bit 0) and read error (bit 1) are clear, the extended-framing bit (bit 6) is clear, and the divider field (bits 15:8) holds 4. MDC is low and the MDIO drive enable is low.
- R2: MDC stays low while idle. During a frame, each MDC half-period lasts max(divider+1, 2) system clock cycles.
- R3: Every frame is 64 bits, sent MSB first: 32 ones, a 2-bit start code, a 2-bit opcode, the 5-bit PHY address, the 5-bit device/register field, 2 turnaround bits (10 when the master drives them), and 16 payload bits. Short framing uses start 01 with opcode 01 for write and 10 for read. Extended framing uses start 00 with opcode 00 for address, 01 for write and 11 for read.
- R4: In extended mode, a write to the register-address register (word 2, bits 15:0) sends an address frame whose payload is that value. In short mode the value is stored and no frame is sent.
- R5: A write to the data register (word 3, bits 15:0) sends a write frame carrying that value. The PHY and device fields are taken from the control register (word 1: PHY address in bits 4:0, device/register field in bits 12:8).
- R6: A control write with bit 15 set loads the address fields and sends a read frame. The master stops driving MDIO from the first turnaround bit onward. It samples the 16 data bits on rising MDC edges, and they are readable in the data register once busy clears.
- R7: If MDIO is not 0 when the second turnaround bit of a read is sampled, the read-error flag is set. The flag is cleared when the next read frame starts.
- R8: While the master drives MDIO, the driven value changes only while MDC is high, one system cycle after a rising MDC edge.
- R9: Busy is set at the clock edge that takes the launching write. It clears at the edge where MDC falls after the last bit, so a frame occupies exactly 128 half-periods.
- R10: While busy is set, writes to every register are ignored. Frame, fields, divider, mode and stored data are left unchanged.
- R11: The control register reads back the PHY address in bits 4:0 and the device field in bits 12:8. The read command bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register word select: 0 status/config, 1 control, 2 register address, 3 data |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational readback of the selected register |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO drive enable; low means released |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
Readback is combinational and follows a write on the next cycle. Busy is checked to stay high for exactly 128 half-periods, that is 128 times max(divider+1, 2) cycles counted from the edge that took the launching write. The read data and the error flag are checked on the first sample after busy clears, because both settle at that same edge. Every bench sample is taken just after a falling system clock edge. The PHY model captures the line on each rising MDC edge, so the frame it records and the master's own sampling refer to the same bit boundaries.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 64;
  localparam int FLD_W      = 5;
  localparam int PAY_W      = 16;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int PAY_FIRST  = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    RA_STAT = 2'd0,
    RA_CTRL = 2'd1,
    RA_REGA = 2'd2,
    RA_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    K_ADDR  = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2
  } frame_kind_e;

  function automatic logic [FRAME_BITS-1:0] make_frame(
    input logic              ext,
    input frame_kind_e       kind,
    input logic [FLD_W-1:0]  phy,
    input logic [FLD_W-1:0]  dev,
    input logic [PAY_W-1:0]  pay
  );
    logic [1:0] st;
    logic [1:0] op;
    st = ext ? 2'b00 : 2'b01;
    case (kind)
      K_ADDR:  op = 2'b00;
      K_WRITE: op = 2'b01;
      default: op = ext ? 2'b11 : 2'b10;
    endcase
    return {{PRE_BITS{1'b1}}, st, op, phy, dev, 2'b10, pay};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] half;
  logic [CW-1:0] cnt;
  logic          tick;

  always_comb begin
    half = (div == '0) ? CW'(2) : ({1'b0, div} + 1'b1);
    tick = run && (cnt == half - 1'b1);
    rise = tick && !mdc;
    fall = tick && mdc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_mdc_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);

  assert_min_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (mdc != $past(mdc))) |-> ($past(mdc, 1) == $past(mdc, 2)));
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  is_read,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  mdc,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  rd_done,
  output logic [PAY_W-1:0]      rd_data,
  output logic                  rd_err
);
  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      idx;
  logic                  last;
  logic                  rise_q;
  logic                  rd_mode;

  always_comb begin
    mdio_o  = shreg[FRAME_BITS-1];
    mdio_oe = busy && !(rd_mode && (idx >= IDX_W'(TA_FIRST)));
    rd_done = busy && fall && last && rd_mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '1;
      idx     <= '0;
      last    <= 1'b0;
      rise_q  <= 1'b0;
      rd_mode <= 1'b0;
      busy    <= 1'b0;
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else begin
      rise_q <= rise;
      if (start) begin
        busy    <= 1'b1;
        shreg   <= frame;
        idx     <= '0;
        last    <= 1'b0;
        rd_mode <= is_read;
        if (is_read) rd_err <= 1'b0;
      end else if (busy) begin
        if (rise) begin
          if (rd_mode && idx == IDX_W'(TA_SECOND) && mdio_i) rd_err <= 1'b1;
          if (rd_mode && idx >= IDX_W'(PAY_FIRST)) rd_data <= {rd_data[PAY_W-2:0], mdio_i};
          if (idx == IDX_W'(FRAME_BITS - 1)) last <= 1'b1;
        end
        if (rise_q && !last) begin
          shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
          idx   <= idx + 1'b1;
        end
        if (fall && last) begin
          busy <= 1'b0;
          last <= 1'b0;
        end
      end
    end
  end

  assert_drive_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> mdc);

  assert_end_on_low_mdc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> !mdc);

  assert_start_mdc_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy)) |-> !mdc);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             ext_q;
  logic [DIV_W-1:0] div_q;
  logic [FLD_W-1:0] phy_q;
  logic [FLD_W-1:0] dev_q;
  logic [PAY_W-1:0] rega_q;
  logic [PAY_W-1:0] data_q;

  logic             busy, rise, fall, rd_done, rd_err;
  logic [PAY_W-1:0] rd_data;
  logic             wr_ok, start;
  frame_kind_e      kind;
  logic [FLD_W-1:0] phy_n, dev_n;
  logic [FRAME_BITS-1:0] frame;

  always_comb begin
    wr_ok = reg_wr && !busy;
    start = 1'b0;
    kind  = K_WRITE;
    phy_n = phy_q;
    dev_n = dev_q;
    if (wr_ok) begin
      case (reg_sel_e'(reg_addr))
        RA_CTRL: begin
          phy_n = reg_wdata[4:0];
          dev_n = reg_wdata[12:8];
          if (reg_wdata[15]) begin
            start = 1'b1;
            kind  = K_READ;
          end
        end
        RA_REGA: if (ext_q) begin
          start = 1'b1;
          kind  = K_ADDR;
        end
        RA_DATA: start = 1'b1;
        default: ;
      endcase
    end
    frame = make_frame(ext_q, kind, phy_n, dev_n,
                       (kind == K_READ) ? '0 : reg_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      div_q  <= DIV_W'(DIV_RESET);
      phy_q  <= '0;
      dev_q  <= '0;
      rega_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_ok) begin
        case (reg_sel_e'(reg_addr))
          RA_STAT: begin
            ext_q <= reg_wdata[6];
            div_q <= reg_wdata[8 +: DIV_W];
          end
          RA_CTRL: begin
            phy_q <= phy_n;
            dev_q <= dev_n;
          end
          RA_REGA: rega_q <= reg_wdata;
          default: data_q <= reg_wdata;
        endcase
      end
      if (rd_done) data_q <= rd_data;
    end
  end

  always_comb begin
    case (reg_sel_e'(reg_addr))
      RA_STAT: reg_rdata = {8'(div_q), 1'b0, ext_q, 4'b0, rd_err, busy};
      RA_CTRL: reg_rdata = {3'b0, dev_q, 3'b0, phy_q};
      RA_REGA: reg_rdata = rega_q;
      default: reg_rdata = data_q;
    endcase
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk (clk),
    .rst_n(rst_n),
    .run (busy),
    .div (div_q),
    .mdc (mdc),
    .rise(rise),
    .fall(fall)
  );

  mdio_frame u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .is_read(kind == K_READ),
    .frame  (frame),
    .rise   (rise),
    .fall   (fall),
    .mdc    (mdc),
    .mdio_i (mdio_i),
    .busy   (busy),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .rd_done(rd_done),
    .rd_data(rd_data),
    .rd_err (rd_err)
  );

  assert_ctrl_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == RA_CTRL) |=> ($stable(phy_q) && $stable(dev_q)));

  assert_cfg_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == RA_STAT) |=> ($stable(div_q) && $stable(ext_q)));

  assert_rega_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == RA_REGA) |=> $stable(rega_q));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_line;

  int checks = 0;
  int fails = 0;

  // PHY model state
  int          rcnt = 0;
  logic [63:0] cap = '0;
  logic        phy_oe = 1'b0, phy_d = 1'b1;
  logic        phy_resp = 1'b1, rd_active = 1'b0;
  logic [15:0] phy_val = '0;
  int          conflicts = 0;
  // monitors
  int          hi_run = 0, last_hi = 0, bad_edges = 0;
  logic        prev_o = 1'b1, prev_oe = 1'b0;
  logic [15:0] last_rega = '0;

  always #10 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_d : 1'b1);

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  always @(posedge mdc) begin
    if (rcnt < 64) cap[63-rcnt] = mdio_line;
    if (phy_oe && mdio_oe) conflicts++;
    rcnt++;
    if (rd_active) begin
      if (rcnt == 46) phy_oe = 1'b0;
      else if (rcnt == 47) begin phy_oe = phy_resp; phy_d = 1'b0; end
      else if (rcnt >= 48 && rcnt <= 63) phy_d = phy_val[63-rcnt];
      else if (rcnt >= 64) phy_oe = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (mdc) hi_run++;
    else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
    if (mdio_oe && prev_oe && (mdio_o != prev_o) && !mdc) bad_edges++;
    prev_o = mdio_o;
    prev_oe = mdio_oe;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
    #1;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_busy(output int n);
    reg_addr = 2'd0;
    #1;
    n = 0;
    while (reg_rdata[0] && n < 100000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  function automatic logic [63:0] exp_frame(bit ext, int kind, logic [4:0] pa,
                                            logic [4:0] da, logic [15:0] pl);
    logic [1:0] s, o;
    s = ext ? 2'b00 : 2'b01;
    if (kind == 0) o = 2'b00;
    else if (kind == 1) o = 2'b01;
    else o = ext ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, s, o, pa, da, 2'b10, pl};
  endfunction

  function automatic int half_of(int dv);
    return (dv < 2) ? 2 : dv + 1;
  endfunction

  // kind: 0 address, 1 write, 2 read
  task automatic run_frame(bit ext, int dv, int kind, logic [4:0] pa,
                           logic [4:0] da, logic [15:0] pl, bit resp);
    int n;
    logic [63:0] e;
    logic [15:0] v;
    wr(2'd0, {dv[7:0], 1'b0, ext, 6'b0});
    phy_resp = resp; phy_val = pl; rd_active = (kind == 2); rcnt = 0; cap = '0;
    if (kind == 2) wr(2'd1, {1'b1, 2'b0, da, 3'b0, pa});
    else begin
      wr(2'd1, {1'b0, 2'b0, da, 3'b0, pa});
      wr((kind == 0) ? 2'd2 : 2'd3, pl);
      if (kind == 0) last_rega = pl;
    end
    wait_busy(n);
    chk("R9 busy length", n, 128 * half_of(dv));
    chk("R2 mdc high time", last_hi, half_of(dv));
    e = exp_frame(ext, kind, pa, da, pl);
    if (kind == 2) begin
      chk("R3 R6 read header", cap[63:18], e[63:18]);
      rd(2'd3, v);
      chk("R6 read data", v, resp ? pl : 16'hFFFF);
      rd(2'd0, v);
      chk("R7 error flag", v[1], !resp);
      rd(2'd1, v);
      chk("R11 ctrl readback", v, {3'b0, da, 3'b0, pa});
    end else begin
      chk(kind == 0 ? "R4 address frame" : "R5 R3 write frame", cap, e);
      rd(kind == 0 ? 2'd2 : 2'd3, v);
      chk(kind == 0 ? "R4 stored address" : "R5 stored data", v, pl);
    end
    rd_active = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v);
    chk("R1 status after reset", v, 16'h0400);
    chk("R1 mdc low", mdc, 1'b0);
    chk("R1 drive enable low", mdio_oe, 1'b0);

    // directed short-framing cases
    run_frame(0, 0, 1, 5'd5, 5'd3, 16'hA5C3, 1);
    run_frame(0, 1, 2, 5'd5, 5'd3, 16'h1E2D, 1);
    run_frame(0, 0, 2, 5'd17, 5'd31, 16'h0F0F, 0);   // R7 no answer
    run_frame(0, 0, 2, 5'd17, 5'd31, 16'h8001, 1);   // R7 cleared

    // R4: short mode address write sends nothing
    rcnt = 0;
    wr(2'd2, 16'h1234);
    last_rega = 16'h1234;
    repeat (10) @(negedge clk);
    #1;
    chk("R4 no frame in short mode", {reg_rdata[0], 31'(rcnt)}, 32'd0);
    rd(2'd2, v);
    chk("R4 stored address short", v, 16'h1234);

    // extended framing
    run_frame(1, 5, 0, 5'd1, 5'd7, 16'hBEEF, 1);
    run_frame(1, 2, 1, 5'd1, 5'd7, 16'h0055, 1);
    run_frame(1, 3, 2, 5'd30, 5'd1, 16'hC001, 1);

    // R10: writes while busy are ignored
    wr(2'd0, 16'h0200);
    wr(2'd1, {3'b0, 5'd9, 3'b0, 5'd3});
    rd_active = 1'b0; rcnt = 0; cap = '0;
    wr(2'd3, 16'h5A5A);
    wr(2'd1, 16'h9F1F);
    wr(2'd0, 16'hFF40);
    wr(2'd3, 16'h1111);
    wr(2'd2, 16'hAAAA);
    wait_busy(n);
    chk("R10 frame unchanged", cap, exp_frame(0, 1, 5'd3, 5'd9, 16'h5A5A));
    rd(2'd1, v);
    chk("R10 ctrl unchanged", v, {3'b0, 5'd9, 3'b0, 5'd3});
    rd(2'd0, v);
    chk("R10 config unchanged", v, 16'h0200);
    rd(2'd3, v);
    chk("R10 data unchanged", v, 16'h5A5A);
    rd(2'd2, v);
    chk("R10 address unchanged", v, last_rega);

    // random mix
    for (int i = 0; i < 24; i++) begin
      bit ext;
      int dv, kind;
      ext = 1'($urandom % 2);
      dv = int'($urandom % 4);
      kind = int'($urandom % 3);
      if (!ext && kind == 0) kind = 1;
      run_frame(ext, dv, kind, 5'($urandom), 5'($urandom), 16'($urandom),
                ($urandom % 8) != 0);
    end

    chk("R8 drive changes only while mdc high", bad_edges, 0);
    chk("R6 bus released during read data", conflicts, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule